// File: doc/BRIEF.md
# Local Memory Access Router

This block sits between a processor's local bus and three memories: a 4-Kbyte on-chip SRAM, a cache controller and external system memory. A read, whether an instruction fetch or a data load, is sent to the SRAM and to the cache controller in the same cycle. One cycle later the block chooses the data source by a fixed priority. The SRAM wins over the cache, and the cache wins over system memory. The losing result is dropped. If neither the SRAM nor the cache hits, the block requests system memory and stalls the requester until that memory signals completion. A write is decoded first, and only the one memory that it targets is enabled.

An internal window register decides whether an address belongs to the SRAM. The register holds a 4-Kbyte aligned base, a valid bit and one mask bit per access type. A masked access type never enables the SRAM, which saves its power on accesses that could not hit it. The cache arrays and the external bus controller are outside the block and appear only as request, hit and data ports. The read response leaves a register, together with a one-hot source indication and a cache allocation enable.

Top module: `lmem_router`

## Requirements
- R1: A read accepted while its address is inside an enabled SRAM window asserts both sram_en and cache_en in the acceptance cycle.
- R2: When a read hits the SRAM window, the response appears two clock edges after acceptance with rsp_data equal to sram_rdata and sram_sel high. This holds even when cache_hit is high.
- R3: When a read misses the SRAM window and cache_hit is high in the cycle after acceptance, the response appears at the next edge with rsp_data equal to cache_rdata and cache_sel high.
- R4: When a read hits neither memory, sys_req rises at the next edge, sys_addr carries the read address, and req_ready stays low while sys_req is high. The edge after a sys_done pulse delivers sys_rdata with ext_sel high and drops sys_req.
- R5: cache_fill is high on responses sourced from system memory and low on SRAM-sourced and cache-sourced responses.
- R6: An accepted write enables exactly one memory with its write strobe: the SRAM when the address hits the window, the cache controller otherwise. sys_req stays low.
- R7: Reads that hit the SRAM or the cache are accepted on consecutive cycles, and their responses appear on consecutive cycles in request order.
- R8: cfg_wdata bit 1 masks instruction fetches (req_type 0), bit 2 masks supervisor data (req_type 1) and bit 3 masks user data (req_type 2). An access whose type bit is set never asserts sram_en and is routed as if outside the window.
- R9: An address hits the window only when the valid bit (cfg_wdata bit 0) is set and address bits [31:12] equal cfg_wdata bits [31:12].
- R10: After reset the window is invalid, so no access enables the SRAM. The outputs rsp_valid and sys_req are low and req_ready is high.
- R11: A configuration write takes effect from the cycle after cfg_we. A request in the same cycle as cfg_we is routed by the old setting.
- R12: Whenever rsp_valid is high, exactly one of sram_sel, cache_sel and ext_sel is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_wdata | input | 32 | Window value: [31:12] base, [3:1] type masks, [0] valid |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read or fetch |
| req_type | input | 2 | 0 fetch, 1 supervisor data, 2 user data |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | 10 | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, the cycle after sram_en |
| cache_en | output | 1 | Cache controller access enable |
| cache_we | output | 1 | Cache controller write strobe |
| cache_addr | output | 32 | Cache controller address |
| cache_wdata | output | 32 | Cache controller write data |
| cache_hit | input | 1 | Cache hit, the cycle after cache_en |
| cache_rdata | input | 32 | Cache read data, the cycle after cache_en |
| sys_req | output | 1 | System memory read request, held until done |
| sys_addr | output | 32 | System memory read address |
| sys_done | input | 1 | System memory completion pulse |
| sys_rdata | input | 32 | System memory read data, valid with sys_done |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| sram_sel | output | 1 | Response came from the SRAM |
| cache_sel | output | 1 | Response came from the cache |
| ext_sel | output | 1 | Response came from system memory |
| cache_fill | output | 1 | Allocate the response into the cache |

## Verification
A corrupted window register shows up in the request cycle as a wrong sram_en. It shows up two edges later as a wrong source select, for example cache data returned for an SRAM address. A lost pending-read flag shows up one edge after the lookup, because sys_req fails to rise or req_ready rises while a miss is outstanding. A stuck flag shows up as a response that never arrives or as a permanent stall. Response-stage faults show up on the edge that delivers the data. Such faults include a bad priority, a select that is not one-hot, or a cache fill on SRAM data.

// File: rtl/lmem_pkg.sv
// Shared definitions for the local memory router.
// Assumes access types are encoded in two bits; code 3 is unused and never masked.
package lmem_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_SUPV  = 2'd1,
        ACC_USER  = 2'd2
    } acc_t;

    localparam int NUM_ACC       = 3;  // access types with a mask bit
    localparam int CFG_VALID_BIT = 0;  // window enable
    localparam int CFG_MASK_LSB  = 1;  // first mask bit, one per access type
endpackage

// File: rtl/lmem_window.sv
// SRAM window register and address decode.
// Holds an aligned base, a valid bit and per-type masks; decodes a hit
// combinationally from the registered value, so a write affects the next access.
module lmem_window
    import lmem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [1:0]        acc_type,
    input  logic [ADDR_W-1:0] addr,
    output logic              win_hit
);
    localparam int BASE_W = ADDR_W - OFS_W;

    logic [BASE_W-1:0]  base_q;
    logic               valid_q;
    logic [NUM_ACC-1:0] mask_q;
    logic [NUM_ACC-1:0] type_dec;
    logic               masked;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[OFS_W-1:CFG_MASK_LSB+NUM_ACC];

    // Register update: reset to an invalid, unmasked window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            valid_q <= 1'b0;
            mask_q  <= '0;
        end else if (cfg_we) begin
            base_q  <= cfg_wdata[ADDR_W-1:OFS_W];
            valid_q <= cfg_wdata[CFG_VALID_BIT];
            mask_q  <= cfg_wdata[CFG_MASK_LSB +: NUM_ACC];
        end
    end

    // One decode line per maskable access type.
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_type
        assign type_dec[g] = (acc_type == 2'(g));
    end

    // Hit decode: valid, base match and type not masked.
    always_comb begin
        masked  = |(type_dec & mask_q);
        win_hit = valid_q && (addr[ADDR_W-1:OFS_W] == base_q) && !masked;
    end

    // R9: a window that is not valid never produces a hit
    p_invalid_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> !win_hit);
    // R8: a masked access type never hits
    p_masked_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type < 2'(NUM_ACC) && mask_q[acc_type]) |-> !win_hit);
endmodule

// File: rtl/lmem_resolve.sv
// Read resolution stage: holds the looked-up read for one cycle, picks the
// source by fixed priority (SRAM, cache, system memory), runs the miss wait
// and registers the response. Assumes SRAM and cache answer the cycle after enable.
module lmem_resolve #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_accept,
    input  logic              rd_sram,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic              cache_hit,
    input  logic [DATA_W-1:0] cache_rdata,
    input  logic              sys_done,
    input  logic [DATA_W-1:0] sys_rdata,
    output logic              miss_now,
    output logic              sys_busy,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              sram_sel,
    output logic              cache_sel,
    output logic              ext_sel,
    output logic              cache_fill
);
    logic              s1_valid;
    logic              s1_sram;
    logic [ADDR_W-1:0] s1_addr;
    logic              ext_done;

    assign miss_now = s1_valid && !s1_sram && !cache_hit;
    assign ext_done = sys_busy && sys_done;

    // Lookup stage: remember which read is waiting for data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sram  <= 1'b0;
            s1_addr  <= '0;
        end else begin
            s1_valid <= rd_accept;
            s1_sram  <= rd_sram;
            s1_addr  <= rd_addr;
        end
    end

    // Miss wait: hold the system request until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_busy <= 1'b0;
            sys_addr <= '0;
        end else if (miss_now) begin
            sys_busy <= 1'b1;
            sys_addr <= s1_addr;
        end else if (ext_done) begin
            sys_busy <= 1'b0;
        end
    end

    // Response register: priority mux and source flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            sram_sel   <= 1'b0;
            cache_sel  <= 1'b0;
            ext_sel    <= 1'b0;
            cache_fill <= 1'b0;
        end else begin
            rsp_valid  <= (s1_valid && (s1_sram || cache_hit)) || ext_done;
            sram_sel   <= s1_valid && s1_sram;
            cache_sel  <= s1_valid && !s1_sram && cache_hit;
            ext_sel    <= ext_done;
            cache_fill <= ext_done;
            if (s1_valid && s1_sram)       rsp_data <= sram_rdata;
            else if (s1_valid && cache_hit) rsp_data <= cache_rdata;
            else                             rsp_data <= sys_rdata;
        end
    end

    // R12: one source flag with every response
    p_rsp_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({sram_sel, cache_sel, ext_sel}));
    // R5: SRAM data is never allocated into the cache
    p_no_fill_sram_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && sram_sel) |-> !cache_fill);
    // R4: the system request holds until its completion
    p_sys_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_busy && !sys_done) |=> sys_busy);
    // R4: an SRAM lookup never raises a system request
    p_sram_no_sys_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_sram) |=> !sys_busy);
endmodule

// File: rtl/lmem_router.sv
// Local memory access router top.
// Reads probe the SRAM (when in window) and the cache together; writes go to
// exactly one memory. Assumes the requester holds a request until req_ready.
module lmem_router
    import lmem_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SRAM_BYTES = 4096,
    localparam int OFS_W     = $clog2(SRAM_BYTES),
    localparam int BYTE_W    = $clog2(DATA_W / 8),
    localparam int SRAM_AW   = OFS_W - BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_type,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               cache_en,
    output logic               cache_we,
    output logic [ADDR_W-1:0]  cache_addr,
    output logic [DATA_W-1:0]  cache_wdata,
    input  logic               cache_hit,
    input  logic [DATA_W-1:0]  cache_rdata,
    output logic               sys_req,
    output logic [ADDR_W-1:0]  sys_addr,
    input  logic               sys_done,
    input  logic [DATA_W-1:0]  sys_rdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               sram_sel,
    output logic               cache_sel,
    output logic               ext_sel,
    output logic               cache_fill
);
    logic win_hit;
    logic accept;
    logic miss_now;

    lmem_window #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .acc_type (req_type),
        .addr     (req_addr),
        .win_hit  (win_hit)
    );

    lmem_resolve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_accept  (accept && !req_write),
        .rd_sram    (win_hit),
        .rd_addr    (req_addr),
        .sram_rdata (sram_rdata),
        .cache_hit  (cache_hit),
        .cache_rdata(cache_rdata),
        .sys_done   (sys_done),
        .sys_rdata  (sys_rdata),
        .miss_now   (miss_now),
        .sys_busy   (sys_req),
        .sys_addr   (sys_addr),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .sram_sel   (sram_sel),
        .cache_sel  (cache_sel),
        .ext_sel    (ext_sel),
        .cache_fill (cache_fill)
    );

    // Request steering: stall on a pending miss, probe in parallel on reads.
    always_comb begin
        req_ready   = !sys_req && !miss_now;
        accept      = req_valid && req_ready;
        sram_en     = accept && win_hit;
        sram_we     = sram_en && req_write;
        cache_en    = accept && (!req_write || !win_hit);
        cache_we    = cache_en && req_write;
        sram_addr   = req_addr[OFS_W-1:BYTE_W];
        sram_wdata  = req_wdata;
        cache_addr  = req_addr;
        cache_wdata = req_wdata;
    end

    // R6: a write touches exactly one memory
    p_write_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |-> ($onehot({sram_we, cache_we}) && !sys_req));
    // R1: an SRAM read is always paired with a cache probe
    p_read_parallel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && !req_write) |-> cache_en);
    // R4: no request is taken while a system read is outstanding
    p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req |-> (!sram_en && !cache_en));
endmodule

// File: tb/lmem_router_bench.sv
module lmem_router_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic        req_valid, req_ready, req_write;
    logic [1:0]  req_type;
    logic [31:0] req_addr, req_wdata;
    logic        sram_en, sram_we;
    logic [9:0]  sram_addr;
    logic [31:0] sram_wdata, sram_rdata;
    logic        cache_en, cache_we, cache_hit;
    logic [31:0] cache_addr, cache_wdata, cache_rdata;
    logic        sys_req, sys_done;
    logic [31:0] sys_addr, sys_rdata;
    logic        rsp_valid, sram_sel, cache_sel, ext_sel, cache_fill;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] WIN   = 32'h2000_0000;
    localparam logic [31:0] FAR   = 32'h3000_0040;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmem_router u_lmem_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .cache_en(cache_en), .cache_we(cache_we), .cache_addr(cache_addr),
        .cache_wdata(cache_wdata), .cache_hit(cache_hit), .cache_rdata(cache_rdata),
        .sys_req(sys_req), .sys_addr(sys_addr), .sys_done(sys_done),
        .sys_rdata(sys_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .sram_sel(sram_sel), .cache_sel(cache_sel), .ext_sel(ext_sel),
        .cache_fill(cache_fill)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // src: 0 SRAM, 1 cache, 2 system memory
    task automatic do_read(input string tag, input logic [31:0] a, input logic [1:0] t,
                           input logic chit, input logic exp_sram_en, input int src);
        logic [31:0] sd, cd, xd, exp_d;
        sd = a ^ 32'h5A5A_0001; cd = a ^ 32'hC0C0_0002; xd = a ^ 32'h0E0E_0003;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_type = t;
        #1;
        chk({tag, " R1 sram_en"}, 32'(sram_en), 32'(exp_sram_en));
        chk({tag, " R1 cache_en"}, 32'(cache_en), 32'd1);
        @(negedge clk);
        req_valid = 1'b0; sram_rdata = sd; cache_hit = chit; cache_rdata = cd;
        #1;
        if (src == 2) chk({tag, " R4 ready low on miss"}, 32'(req_ready), 32'd0);
        @(negedge clk);
        cache_hit = 1'b0;
        if (src == 2) begin
            chk({tag, " R4 sys_req"}, 32'(sys_req), 32'd1);
            chk({tag, " R4 sys_addr"}, sys_addr, a);
            @(negedge clk);
            @(negedge clk);
            chk({tag, " R4 still stalled"}, {30'd0, sys_req, req_ready}, 32'd2);
            sys_done = 1'b1; sys_rdata = xd;
            @(negedge clk);
            sys_done = 1'b0;
            chk({tag, " R4 sys_req dropped"}, 32'(sys_req), 32'd0);
        end
        exp_d = (src == 0) ? sd : (src == 1) ? cd : xd;
        chk({tag, " R12 rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " R2/R3/R4 data"}, rsp_data, exp_d);
        chk({tag, " R12 sel"}, {29'd0, sram_sel, cache_sel, ext_sel},
            (src == 0) ? 32'd4 : (src == 1) ? 32'd2 : 32'd1);
        chk({tag, " R5 cache_fill"}, 32'(cache_fill), 32'(src == 2));
    endtask

    task automatic do_write(input string tag, input logic [31:0] a, input logic [1:0] t,
                            input logic to_sram);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_type = t; req_wdata = ~a;
        #1;
        chk({tag, " R6 sram en/we"}, {30'd0, sram_en, sram_we}, to_sram ? 32'd3 : 32'd0);
        chk({tag, " R6 cache en/we"}, {30'd0, cache_en, cache_we}, to_sram ? 32'd0 : 32'd3);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk({tag, " R6 no sys_req"}, 32'(sys_req), 32'd0);
    endtask

    task automatic test_reset;
        chk("R10 ready", 32'(req_ready), 32'd1);
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 sys_req", 32'(sys_req), 32'd0);
        do_read("R10 read after reset", WIN, 2'd2, 1'b1, 1'b0, 1);
    endtask

    task automatic test_priority;
        set_cfg(WIN | 32'h1);
        do_read("R2 sram over cache", WIN + 32'h10, 2'd1, 1'b1, 1'b1, 0);
        do_read("R2 fetch window", WIN + 32'hFFC, 2'd0, 1'b0, 1'b1, 0);
        do_read("R3 cache hit", FAR, 2'd2, 1'b1, 1'b0, 1);
        do_read("R4 miss", FAR + 32'h4, 2'd1, 1'b0, 1'b0, 2);
        do_read("R9 next page", WIN + 32'h1000, 2'd2, 1'b1, 1'b0, 1);
    endtask

    task automatic test_writes;
        do_write("R6 sram write", WIN + 32'h20, 2'd2, 1'b1);
        do_write("R6 cache write", FAR, 2'd2, 1'b0);
    endtask

    task automatic test_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_type = 2'd1; req_addr = WIN + 32'h40;
        @(negedge clk);
        req_addr = FAR + 32'h80; sram_rdata = 32'hAAAA_0001; cache_hit = 1'b1;
        cache_rdata = 32'hBBBB_0001;
        #1;
        chk("R7 second accepted", {30'd0, req_ready, cache_en}, 32'd3);
        @(negedge clk);
        req_valid = 1'b0; cache_hit = 1'b1; cache_rdata = 32'hBBBB_0002;
        chk("R7 first rsp", rsp_data, 32'hAAAA_0001);
        chk("R7 first sel", 32'(sram_sel && rsp_valid), 32'd1);
        @(negedge clk);
        cache_hit = 1'b0;
        chk("R7 second rsp", rsp_data, 32'hBBBB_0002);
        chk("R7 second sel", 32'(cache_sel && rsp_valid), 32'd1);
    endtask

    task automatic test_masks;
        set_cfg(WIN | 32'h3);
        do_read("R8 fetch masked", WIN + 32'h8, 2'd0, 1'b1, 1'b0, 1);
        do_read("R8 user unmasked", WIN + 32'h8, 2'd2, 1'b1, 1'b1, 0);
        do_write("R8 masked write", WIN + 32'h8, 2'd0, 1'b0);
        set_cfg(WIN | 32'h9);
        do_read("R8 user masked", WIN + 32'hC, 2'd2, 1'b1, 1'b0, 1);
        do_read("R8 supv unmasked", WIN + 32'hC, 2'd1, 1'b1, 1'b1, 0);
        set_cfg(WIN | 32'h5);
        do_read("R8 supv masked", WIN + 32'hC, 2'd1, 1'b0, 1'b0, 2);
    endtask

    task automatic test_cfg_timing;
        set_cfg(WIN | 32'h1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = WIN;
        req_valid = 1'b1; req_write = 1'b0; req_type = 2'd2; req_addr = WIN + 32'h4;
        #1;
        chk("R11 old setting used", 32'(sram_en), 32'd1);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0; sram_rdata = 32'h1234_5678; cache_hit = 1'b0;
        @(negedge clk);
        chk("R11 same-cycle read from sram", {rsp_data[31:1], sram_sel}, {31'h091A_2B3C, 1'b1});
        do_read("R11 new setting", WIN + 32'h4, 2'd2, 1'b1, 1'b0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req_valid = 1'b0; req_write = 1'b0;
        req_type = 2'd0; req_addr = '0; req_wdata = '0; sram_rdata = '0; cache_hit = 1'b0;
        cache_rdata = '0; sys_done = 1'b0; sys_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_priority();
        test_writes();
        test_back_to_back();
        test_masks();
        test_cfg_timing();
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule